// File: doc/BRIEF.md
# Split Dual-PWM Audio DAC

This block turns a 10-bit audio sample into two 8-bit pulse-width waveforms that an external resistor network sums into one analog level. The upper eight bits of the sample set the duty of a coarse channel. The lower two bits, zero-extended to eight bits, set the duty of a fine channel. The mixer weights the fine channel by one quarter. Both channels share one free-running 8-bit counter, so the PWM period is 256 clocks, and that period is also the audio sample period.

Each time the counter wraps, the block pulses a start-conversion request for the ADC and a sample strobe for the delay datapath. The datapath may write a new sample into a holding register at any time. The two compare values that the channels actually use are reloaded from that holding register only at the wrap, so a period never changes duty halfway through. Both outputs run inverted: an output is low while the counter is below its compare value and high from that point on.

Top module: `split_pwm_dac`

## Requirements
- R1: The counter counts 0 to 255 and wraps. `adc_start_o` is high for exactly one clock per 256-clock period, in the cycle where the counter reads 0 after a wrap. It is not high in the first period after reset.
- R2: `sample_stb_o` is high in exactly the same cycles as `adc_start_o`.
- R3: The coarse channel compare value is sample bits [9:2]. `coarse_pwm_o` is low for the first (compare value) cycles of a period and high for the remaining cycles.
- R4: The fine channel compare value is sample bits [1:0] in compare bits [1:0], with compare bits [7:2] zero. `fine_pwm_o` is low for the first (compare value) cycles of a period and high for the rest.
- R5: A compare value of 0 keeps its output high for the whole period. The all-ones sample 0x3FF gives coarse low for 255 cycles and fine low for 3 cycles.
- R6: While reset is asserted and after it is released, the active and held sample is 0x200. The coarse compare value is then 0x80 and the fine compare value is 0x00, so `coarse_pwm_o` is low and `fine_pwm_o` is high during reset.
- R7: When `sample_we_i` is high at a clock edge, `sample_i` is held. The outputs of the current period do not change. The held value takes effect from the first cycle of the next period.
- R8: Only the last write before the wrap edge counts. A write that is sampled at the wrap edge itself (counter reads 255) is used one period later, and the period that starts at that edge uses the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_we_i | input | 1 | Sample write enable |
| sample_i | input | 10 | Unsigned 10-bit sample, mid-scale 0x200 |
| coarse_pwm_o | output | 1 | Inverted PWM for sample bits [9:2] |
| fine_pwm_o | output | 1 | Inverted PWM for sample bits [1:0] |
| adc_start_o | output | 1 | One-clock start-conversion pulse per period |
| sample_stb_o | output | 1 | One-clock sample strobe per period |

## Verification
A write that is sampled at edge N is in the holding register after that edge. It reaches the outputs only in the cycle where the counter reads 0 after the next wrap edge. Both strobes are high in that same cycle. Each PWM output is registered, so in every cycle it shows the comparison of that cycle's counter value against that cycle's compare value. A behavioural model in the bench tracks the counter, the held sample and the active sample. It advances on the same edges as the design, and the bench compares all four outputs against it on each falling edge, half a cycle after the outputs settle. Writes are placed at chosen counter positions, including position 255, so that the one-period delay and the last-write-wins rule fall on exact cycles.

// File: rtl/split_pwm_pkg.sv
package split_pwm_pkg;
  localparam int unsigned DEF_CNT_W    = 8;
  localparam int unsigned DEF_SAMPLE_W = 10;

  typedef enum logic {
    CH_COARSE = 1'b0,
    CH_FINE   = 1'b1
  } pwm_ch_e;

  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CNT_W = split_pwm_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             adc_start_o,
  output logic             sample_stb_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             adc_q, stb_q;

  assign wrap_o = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      adc_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= CNT_W'(cnt_q + 1'b1);
      adc_q <= wrap_o;
      stb_q <= wrap_o;
    end
  end

  assign cnt_o        = cnt_q;
  assign adc_start_o  = adc_q;
  assign sample_stb_o = stb_q;

  assert_wrap_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
  assert_start_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_q |=> !adc_q);
  assert_start_at_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_q |-> (cnt_q == '0));
endmodule

// File: rtl/duty_shadow.sv
module duty_shadow #(
  parameter int unsigned     SAMPLE_W = split_pwm_pkg::DEF_SAMPLE_W,
  parameter logic [SAMPLE_W-1:0] RST_VAL = {1'b1, {(SAMPLE_W-1){1'b0}}}
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [SAMPLE_W-1:0] data_i,
  output logic [SAMPLE_W-1:0] q_o
);
  logic [SAMPLE_W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= RST_VAL;
    else if (we_i) q_q <= data_i;
  end

  assign q_o = q_q;

  assert_shadow_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_q == $past(data_i)));
  assert_shadow_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_q));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int unsigned      CNT_W   = split_pwm_pkg::DEF_CNT_W,
  parameter logic [CNT_W-1:0] RST_CMP = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cmp_next_i,
  output logic             pwm_o
);
  localparam logic PWM_RST = (RST_CMP == '0);

  logic [CNT_W-1:0] cmp_q, cmp_d, cnt_d;
  logic             pwm_q;

  // values valid in the coming cycle
  assign cnt_d = CNT_W'(cnt_i + 1'b1);
  assign cmp_d = wrap_i ? cmp_next_i : cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= RST_CMP;
      pwm_q <= PWM_RST;
    end else begin
      cmp_q <= cmp_d;
      pwm_q <= (cnt_d >= cmp_d);
    end
  end

  assign pwm_o = pwm_q;

  assert_load_at_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> (cmp_q == $past(cmp_next_i)));
  assert_hold_mid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(cmp_q));
  assert_inverted_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_q |-> (cnt_i < cmp_q));
  assert_zero_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_q == '0) |-> pwm_q);
endmodule

// File: rtl/split_pwm_dac.sv
module split_pwm_dac #(
  parameter int unsigned CNT_W    = split_pwm_pkg::DEF_CNT_W,
  parameter int unsigned SAMPLE_W = split_pwm_pkg::DEF_SAMPLE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_we_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                coarse_pwm_o,
  output logic                fine_pwm_o,
  output logic                adc_start_o,
  output logic                sample_stb_o
);
  import split_pwm_pkg::*;

  localparam int unsigned FINE_W = SAMPLE_W - CNT_W;
  localparam logic [SAMPLE_W-1:0] MID_SAMPLE = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] RST_COARSE = MID_SAMPLE[SAMPLE_W-1 -: CNT_W];
  localparam logic [CNT_W-1:0] RST_FINE   = CNT_W'(MID_SAMPLE[FINE_W-1:0]);

  logic [CNT_W-1:0]    cnt;
  logic                wrap;
  logic [SAMPLE_W-1:0] held;
  logic [NUM_CH-1:0]   pwm;

  pwm_timebase #(.CNT_W(CNT_W)) i_timebase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_o       (cnt),
    .wrap_o      (wrap),
    .adc_start_o (adc_start_o),
    .sample_stb_o(sample_stb_o)
  );

  duty_shadow #(.SAMPLE_W(SAMPLE_W), .RST_VAL(MID_SAMPLE)) i_shadow (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (sample_we_i),
    .data_i(sample_i),
    .q_o   (held)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CNT_W-1:0] cmp_src;
    if (ch == int'(CH_COARSE)) begin : g_coarse
      assign cmp_src = held[SAMPLE_W-1 -: CNT_W];
      pwm_channel #(.CNT_W(CNT_W), .RST_CMP(RST_COARSE)) i_chan (
        .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .wrap_i(wrap),
        .cmp_next_i(cmp_src), .pwm_o(pwm[ch])
      );
    end else begin : g_fine
      assign cmp_src = CNT_W'(held[FINE_W-1:0]);
      pwm_channel #(.CNT_W(CNT_W), .RST_CMP(RST_FINE)) i_chan (
        .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .wrap_i(wrap),
        .cmp_next_i(cmp_src), .pwm_o(pwm[ch])
      );
    end
  end

  assign coarse_pwm_o = pwm[CH_COARSE];
  assign fine_pwm_o   = pwm[CH_FINE];

  assert_strobe_pair_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_stb_o |=> !sample_stb_o);
endmodule

// File: tb/test_split_pwm_dac.sv
module test_split_pwm_dac;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [9:0] smp = '0;
  logic       coarse, fine, adc, stb;

  int errors = 0;
  int checks = 0;
  string phase = "R6";
  bit cmp_en = 1'b0;

  int m_cnt, m_shadow, m_active;
  bit m_stb;

  always #10 clk = ~clk;

  split_pwm_dac i_split_pwm_dac (
    .clk_i(clk), .rst_ni(rst_n), .sample_we_i(we), .sample_i(smp),
    .coarse_pwm_o(coarse), .fine_pwm_o(fine),
    .adc_start_o(adc), .sample_stb_o(stb)
  );

  // behavioural reference: period 256, wrap reloads active from held value
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_shadow = 'h200; m_active = 'h200; m_stb = 1'b0;
    end else begin
      if (m_cnt == 255) begin
        m_active = m_shadow; m_cnt = 0; m_stb = 1'b1;
      end else begin
        m_cnt = m_cnt + 1; m_stb = 1'b0;
      end
      if (we) m_shadow = int'(smp);
    end
  end

  task automatic check(input bit got, input bit exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s (%s) t=%0t cnt=%0d got=%0b exp=%0b", req, phase, $time, m_cnt, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      check(coarse, m_cnt >= (m_active >> 2), "R3 coarse");
      check(fine,   m_cnt >= (m_active & 3),  "R4 fine");
      check(adc,    m_stb,                    "R1 adc_start");
      check(stb,    m_stb,                    "R2 sample_stb");
    end
  end

  task automatic write_at(input int pos, input logic [9:0] v);
    @(negedge clk);
    while (m_cnt != pos) @(negedge clk);
    we = 1'b1; smp = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R6: reset state
    repeat (3) @(negedge clk);
    check(coarse, 1'b0, "R6 coarse in reset");
    check(fine,   1'b1, "R6 fine in reset");
    check(adc,    1'b0, "R6 adc_start in reset");
    check(stb,    1'b0, "R6 sample_stb in reset");
    rst_n = 1'b1;
    cmp_en = 1'b1;
    repeat (300) @(negedge clk);

    // R7: mid-period write must not disturb the running period
    phase = "R7";
    write_at(100, 10'h3FF);
    repeat (600) @(negedge clk);

    // R5: zero sample keeps both outputs high
    phase = "R5";
    write_at(40, 10'h000);
    repeat (600) @(negedge clk);

    // R8: write at wrap edge is deferred one period; last write wins
    phase = "R8";
    write_at(255, 10'h155);
    write_at(10, 10'h123);
    write_at(20, 10'h0C6);
    repeat (600) @(negedge clk);

    // R3 / R4: assorted patterns
    phase = "R3_R4";
    for (int k = 0; k < 4; k++) begin
      write_at(50 + k, (k == 0) ? 10'h201 : (k == 1) ? 10'h1FE : (k == 2) ? 10'h0FF : 10'h302);
      repeat (300) @(negedge clk);
    end
    cmp_en = 1'b0;
    finish_run();
  end
endmodule